// File: doc/BRIEF.md
# Circular Capture Buffer Controller

This block manages the on-chip sample memory of an embedded logic analyzer. Once armed, it writes every clock's worth of channel samples into a ring buffer, and each new sample replaces the oldest one after the ring has filled. A trigger strobe marks the event of interest. The controller then gathers a number of post-trigger samples set by the selected trigger position. After that it stops writing and hands the stored window to a sequential readout port, oldest sample first, using a valid/ready handshake.

The controller has four states. `ST_IDLE` waits for a command. `ST_ARMED` writes samples and watches for the trigger. `ST_POST` writes the remaining post-trigger samples. `ST_UPLOAD` streams the window out and writes nothing.

The transitions are:
- arm: `ST_IDLE` to `ST_ARMED`, on run or auto-run.
- trigger hit: `ST_ARMED` to `ST_POST`, or straight to `ST_UPLOAD` when only one post sample is due.
- post done: `ST_POST` to `ST_UPLOAD`.
- stop: `ST_ARMED`/`ST_POST` to `ST_UPLOAD`.
- upload done: `ST_UPLOAD` to `ST_IDLE`.
- re-arm: `ST_UPLOAD` to `ST_ARMED`, in auto-run mode.

The requested channel count `CH_IN` is widened to the next power of two on the readout side. The depth is `2**DEPTH_LOG2`, intended for 128 to 2048 entries.

Top module: `cap_ring_ctrl`

## Requirements
- R1: After reset, idle_o is 1, busy_o is 0, rd_valid_o is 0 and short_o is 0.
- R2: A run_i or auto_i pulse in idle arms the block (busy_o=1). From the next clock on, every cycle's samp_i is written into the ring, and the ring overwrites its oldest entry once DEPTH samples are stored.
- R3: pos_i is latched at each arm. Code 0 keeps round(DEPTH*0.92) samples before the trigger, code 1 keeps DEPTH/2, and code 2 keeps round(DEPTH*0.12). The sample present in the trigger cycle is the first of the DEPTH minus pre-count post-trigger samples, so a full window holds DEPTH samples.
- R4: The readout presents the window oldest first, with rd_addr_o counting 0,1,2,…. A beat completes when rd_valid_o and rd_ready_i are both high, and while rd_ready_i is low, rd_addr_o and rd_data_o hold.
- R5: If the trigger comes with fewer than the pre-count samples stored, the window is all stored samples plus the post-trigger samples, and short_o reads 1 until the next arm. Otherwise short_o reads 0.
- R6: With pos_i code 3 (continuous), trig_i has no effect. Only a stop ends sampling.
- R7: stop_i while armed or collecting post samples writes nothing in that cycle and uploads the most recent min(n, DEPTH) samples. stop_i in idle has no effect.
- R8: No sample is written during upload, and run_i and auto_i are ignored while busy.
- R9: After the last beat, a run-started capture returns to idle. An auto-run capture re-arms in the same edge and writes from the next cycle.
- R10: A stop, even one given during upload, ends auto-run: the current upload completes and the block then goes idle.
- R11: rd_data_o is 2**ceil(log2(CH_IN)) bits wide, with the bits above CH_IN reading 0.
- R12: A stop given immediately after arming produces an upload of zero beats and returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Acquisition clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_i | input | CH_IN | Channel samples |
| trig_i | input | 1 | Trigger event strobe |
| run_i | input | 1 | Arm for one capture |
| auto_i | input | 1 | Arm in auto-run mode |
| stop_i | input | 1 | End acquisition or auto-run |
| pos_i | input | 2 | Trigger position: 0 mostly-before, 1 centre, 2 mostly-after, 3 continuous |
| rd_ready_i | input | 1 | Readout consumer ready |
| rd_valid_o | output | 1 | Readout beat valid |
| rd_addr_o | output | DEPTH_LOG2 | Index of the beat within the window |
| rd_data_o | output | 2**ceil(log2(CH_IN)) | Sample, zero padded |
| busy_o | output | 1 | Armed, collecting or uploading |
| idle_o | output | 1 | Waiting for a command |
| short_o | output | 1 | Last triggered window had an incomplete pre-trigger part |

## Verification
The assertions check several rules on every cycle:
- the readout holds its address and data while stalled, and steps the address by one per beat;
- nothing is written while a beat is offered, and the fill count never exceeds the depth;
- a stop forces the upload state, and continuous mode stays armed;
- an arm command leads to busy.

Only the bench scenarios can show which samples land in the window. That covers window placement across ring wrap-around for each trigger position, the truncated windows with the short flag, and the re-arm and stop sequencing of auto-run. All of these are compared against a log of the samples the bench drove.

// File: rtl/cap_pkg.sv
`timescale 1ns/1ps
package cap_pkg;
    typedef enum logic [1:0] {
        POS_HIST = 2'd0,
        POS_MID  = 2'd1,
        POS_FWD  = 2'd2,
        POS_FREE = 2'd3
    } cap_pos_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_POST,
        ST_UPLOAD
    } cap_state_e;
endpackage

// File: rtl/cap_window_calc.sv
`timescale 1ns/1ps
module cap_window_calc
    import cap_pkg::*;
#(
    parameter int AW = 7
) (
    input  cap_pos_e       pos,
    output logic [AW:0]    pre_n,
    output logic [AW:0]    post_n
);
    localparam int unsigned D = 1 << AW;
    localparam logic [AW:0] FULL     = (AW+1)'(D);
    localparam logic [AW:0] PRE_HIST = (AW+1)'((D * 92 + 50) / 100);
    localparam logic [AW:0] PRE_MID  = (AW+1)'(D / 2);
    localparam logic [AW:0] PRE_FWD  = (AW+1)'((D * 12 + 50) / 100);

    always_comb begin
        unique case (pos)
            POS_HIST: pre_n = PRE_HIST;
            POS_MID:  pre_n = PRE_MID;
            POS_FWD:  pre_n = PRE_FWD;
            POS_FREE: pre_n = '0;
        endcase
        post_n = FULL - pre_n;
    end
endmodule

// File: rtl/cap_wr_track.sv
`timescale 1ns/1ps
module cap_wr_track #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    output logic [AW-1:0] wptr,
    output logic [AW:0]   fill
);
    localparam logic [AW:0] FULL = (AW+1)'(1 << AW);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            fill <= '0;
        end else if (clr) begin
            wptr <= '0;
            fill <= '0;
        end else if (we) begin
            wptr <= wptr + 1'b1;
            if (fill != FULL) fill <= fill + 1'b1;
        end
    end

    // R2: the count of stored samples saturates at the ring depth
    p_fill_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FULL);
    // R2: arming starts an empty window
    p_clr_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> fill == '0);
endmodule

// File: rtl/cap_ring_mem.sv
`timescale 1ns/1ps
module cap_ring_mem #(
    parameter int W  = 6,
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;
    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/cap_ring_ctrl.sv
`timescale 1ns/1ps
module cap_ring_ctrl
    import cap_pkg::*;
#(
    parameter int CH_IN      = 6,
    parameter int DEPTH_LOG2 = 7
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [CH_IN-1:0]                    samp_i,
    input  logic                                trig_i,
    input  logic                                run_i,
    input  logic                                auto_i,
    input  logic                                stop_i,
    input  logic [1:0]                          pos_i,
    input  logic                                rd_ready_i,
    output logic                                rd_valid_o,
    output logic [DEPTH_LOG2-1:0]               rd_addr_o,
    output logic [(1 << $clog2(CH_IN))-1:0]     rd_data_o,
    output logic                                busy_o,
    output logic                                idle_o,
    output logic                                short_o
);
    localparam int AW    = DEPTH_LOG2;
    localparam int CHANS = 1 << $clog2(CH_IN);

    cap_state_e       state_q, state_d;
    cap_pos_e         pos_q;
    logic             auto_q;
    logic             short_q;
    logic [AW:0]      post_left_q;
    logic [AW:0]      idx_q;

    logic [AW:0]      pre_n, post_n;
    logic [AW-1:0]    wptr;
    logic [AW:0]      fill;
    logic             mem_we, arm_go, trig_hit, upl_done, hs;
    logic [AW:0]      idx_inc;
    logic [AW-1:0]    base, raddr;
    logic [CH_IN-1:0] mem_rdata;

    localparam logic [AW:0] ONE = (AW+1)'(1);

    cap_window_calc #(.AW(AW)) u_win (
        .pos    (pos_q),
        .pre_n  (pre_n),
        .post_n (post_n)
    );

    cap_wr_track #(.AW(AW)) u_trk (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (arm_go),
        .we    (mem_we),
        .wptr  (wptr),
        .fill  (fill)
    );

    assign base  = wptr - fill[AW-1:0];
    assign raddr = base + idx_q[AW-1:0];

    cap_ring_mem #(.W(CH_IN), .AW(AW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (wptr),
        .wdata (samp_i),
        .raddr (raddr),
        .rdata (mem_rdata)
    );

    generate
        if (CHANS > CH_IN) begin : g_pad
            assign rd_data_o = {{(CHANS-CH_IN){1'b0}}, mem_rdata};
        end else begin : g_nopad
            assign rd_data_o = mem_rdata;
        end
    endgenerate

    // handshake and end-of-upload detection
    assign hs       = rd_valid_o && rd_ready_i;
    assign idx_inc  = idx_q + {{AW{1'b0}}, hs};
    assign upl_done = (state_q == ST_UPLOAD) && (idx_inc == fill);
    assign trig_hit = (state_q == ST_ARMED) && trig_i && !stop_i && (pos_q != POS_FREE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        arm_go  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (run_i || auto_i) begin
                    state_d = ST_ARMED;
                    arm_go  = 1'b1;
                end
            end
            ST_ARMED: begin
                if (stop_i)        state_d = ST_UPLOAD;
                else if (trig_hit) state_d = (post_n == ONE) ? ST_UPLOAD : ST_POST;
            end
            ST_POST: begin
                if (stop_i || post_left_q == ONE) state_d = ST_UPLOAD;
            end
            ST_UPLOAD: begin
                if (upl_done) begin
                    if (auto_q && !stop_i) begin
                        state_d = ST_ARMED;
                        arm_go  = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        mem_we     = 1'b0;
        rd_valid_o = 1'b0;
        busy_o     = 1'b1;
        idle_o     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o = 1'b0;
                idle_o = 1'b1;
            end
            ST_ARMED, ST_POST: mem_we = !stop_i;
            ST_UPLOAD:         rd_valid_o = (idx_q < fill);
        endcase
    end

    assign rd_addr_o = idx_q[AW-1:0];
    assign short_o   = short_q;

    // capture bookkeeping registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auto_q      <= 1'b0;
            pos_q       <= POS_HIST;
            short_q     <= 1'b0;
            post_left_q <= '0;
            idx_q       <= '0;
        end else begin
            if (stop_i)                                          auto_q <= 1'b0;
            else if (state_q == ST_IDLE && (run_i || auto_i))    auto_q <= auto_i;

            if (arm_go) pos_q <= cap_pos_e'(pos_i);

            if (arm_go)        short_q <= 1'b0;
            else if (trig_hit) short_q <= (fill < pre_n);

            if (trig_hit)                             post_left_q <= post_n - ONE;
            else if (state_q == ST_POST && mem_we)    post_left_q <= post_left_q - ONE;

            if (state_q != ST_UPLOAD) idx_q <= '0;
            else                      idx_q <= idx_inc;
        end
    end

    // R2: an arm command makes the block busy without offering data
    p_arm_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && (run_i || auto_i)) |=> (busy_o && !rd_valid_o));
    // R4: a stalled beat keeps address and data
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_addr_o) && $stable(rd_data_o)));
    // R4: each accepted beat advances the address by one
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && rd_ready_i) |=> (!rd_valid_o || rd_addr_o == $past(rd_addr_o) + 1'b1));
    // R6: continuous mode stays armed until a stop
    p_free_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && pos_q == POS_FREE && !stop_i) |=> state_q == ST_ARMED);
    // R7: a stop during acquisition goes straight to upload
    p_stop_upload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ARMED || state_q == ST_POST) && stop_i) |=> state_q == ST_UPLOAD);
    // R8: nothing is written while a beat is offered
    p_no_write_upload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> !mem_we);
    // R10: a finished upload without auto-run leads to idle
    p_end_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (upl_done && (!auto_q || stop_i)) |=> idle_o);
endmodule

// File: tb/tb_cap_ring_ctrl.sv
`timescale 1ns/1ps
module tb_cap_ring_ctrl;
    localparam int CH_IN = 6;
    localparam int DL    = 7;
    localparam int D     = 1 << DL;
    localparam int CHANS = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [CH_IN-1:0] samp_i;
    logic             trig_i, run_i, auto_i, stop_i, rd_ready_i;
    logic [1:0]       pos_i;
    logic             rd_valid_o, busy_o, idle_o, short_o;
    logic [DL-1:0]    rd_addr_o;
    logic [CHANS-1:0] rd_data_o;

    int checks = 0;
    int errors = 0;
    int n      = 0;
    logic [CH_IN-1:0] lg [0:1023];

    always #4 clk = ~clk;

    cap_ring_ctrl #(.CH_IN(CH_IN), .DEPTH_LOG2(DL)) dut (
        .clk(clk), .rst_n(rst_n), .samp_i(samp_i), .trig_i(trig_i),
        .run_i(run_i), .auto_i(auto_i), .stop_i(stop_i), .pos_i(pos_i),
        .rd_ready_i(rd_ready_i), .rd_valid_o(rd_valid_o), .rd_addr_o(rd_addr_o),
        .rd_data_o(rd_data_o), .busy_o(busy_o), .idle_o(idle_o), .short_o(short_o)
    );

    function automatic int exp_pre(input int p);
        case (p)
            0:       return (D * 92 + 50) / 100;
            1:       return D / 2;
            2:       return (D * 12 + 50) / 100;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic start_run(input int p, input bit use_auto);
        pos_i  = 2'(p);
        run_i  = !use_auto;
        auto_i = use_auto;
        n      = 0;
        @(negedge clk);
        run_i  = 1'b0;
        auto_i = 1'b0;
        chk(busy_o == 1'b1, "R2 busy after arm", busy_o, 1);
    endtask

    task automatic feed(input int cnt, input int trig_at);
        for (int i = 0; i < cnt; i++) begin
            samp_i = CH_IN'($urandom);
            lg[n]  = samp_i;
            n++;
            trig_i = (i == trig_at);
            @(negedge clk);
        end
        trig_i = 1'b0;
    endtask

    task automatic do_stop();
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
    endtask

    task automatic readout(input int len, input int first, input string tag,
                           input int stop_beat, input bit poke);
        int  k     = 0;
        int  guard = 0;
        bit  sd    = 1'b0;
        if (len == 0) begin
            chk(rd_valid_o == 1'b0, {tag, " empty upload"}, rd_valid_o, 0);
            @(negedge clk);
            return;
        end
        while (k < len && guard < 4000) begin
            rd_ready_i = ($urandom_range(3) != 0);
            samp_i     = CH_IN'($urandom);
            run_i      = poke;
            auto_i     = poke;
            if (k == stop_beat && !sd) begin
                stop_i = 1'b1;
                sd     = 1'b1;
            end else begin
                stop_i = 1'b0;
            end
            if (rd_valid_o && rd_ready_i) begin
                chk(rd_addr_o == DL'(k), {tag, " R4 addr"}, rd_addr_o, k);
                chk(rd_data_o == CHANS'(lg[first + k]), {tag, " R3/R11 data"},
                    rd_data_o, CHANS'(lg[first + k]));
                k++;
            end
            guard++;
            @(negedge clk);
        end
        rd_ready_i = 1'b0;
        run_i      = 1'b0;
        auto_i     = 1'b0;
        stop_i     = 1'b0;
        chk(k == len, {tag, " R4 beat count"}, k, len);
        chk(rd_valid_o == 1'b0, {tag, " R4 no extra beat"}, rd_valid_o, 0);
    endtask

    // triggered capture: drive t pre samples and the post samples, then read back
    task automatic cap_body(input int p, input int t, input string tag,
                            input int stop_beat, input bit poke);
        int pre  = exp_pre(p);
        int post = D - pre;
        int pa   = (t < pre) ? t : pre;
        feed(t + post, t);
        chk(short_o == (t < pre), {tag, " R5 short flag"}, short_o, (t < pre));
        readout(pa + post, t - pa, tag, stop_beat, poke);
    endtask

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; samp_i = '0; trig_i = 0; run_i = 0; auto_i = 0;
        stop_i = 0; pos_i = 0; rd_ready_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(idle_o == 1'b1,     "R1 idle",  idle_o, 1);
        chk(busy_o == 1'b0,     "R1 busy",  busy_o, 0);
        chk(rd_valid_o == 1'b0, "R1 valid", rd_valid_o, 0);
        chk(short_o == 1'b0,    "R1 short", short_o, 0);

        // R3 directed: each position with a full pre-trigger region (ring wraps)
        start_run(0, 0); cap_body(0, 150, "R3 hist", -1, 0);
        chk(idle_o == 1'b1, "R9 idle after single", idle_o, 1);
        start_run(1, 0); cap_body(1, 70, "R3 mid", -1, 0);
        start_run(2, 0); cap_body(2, 20, "R3 fwd", -1, 0);
        // R5 short windows, including a trigger on the first sample
        start_run(0, 0); cap_body(0, 30, "R5 short", -1, 0);
        start_run(1, 0); cap_body(1, 0, "R5 first", -1, 0);
        // R8 run and auto pulses during upload are ignored
        start_run(2, 0); cap_body(2, 40, "R8 poke", -1, 1);
        chk(idle_o == 1'b1, "R8 idle after poked upload", idle_o, 1);
        // random trigger positions and times
        for (int it = 0; it < 8; it++) begin
            int p = $urandom_range(2);
            int t = $urandom_range(300);
            start_run(p, 0); cap_body(p, t, "R3 rand", -1, 0);
            chk(idle_o == 1'b1, "R9 idle rand", idle_o, 1);
        end
        // R6 continuous: triggers ignored, stop ends sampling
        start_run(3, 0);
        feed(150, 20);
        feed(150, 5);
        chk(busy_o == 1'b1 && rd_valid_o == 1'b0, "R6 still sampling", rd_valid_o, 0);
        do_stop();
        readout(D, n - D, "R6 free", -1, 0);
        // R7 stop before the ring fills
        start_run(0, 0);
        feed(50, -1);
        do_stop();
        readout(50, 0, "R7 early stop", -1, 0);
        chk(idle_o == 1'b1, "R7 idle after stop", idle_o, 1);
        // R7 stop in idle has no effect
        do_stop();
        chk(idle_o == 1'b1 && rd_valid_o == 1'b0, "R7 stop in idle", idle_o, 1);
        // R12 empty capture
        start_run(1, 0);
        do_stop();
        readout(0, 0, "R12", -1, 0);
        chk(idle_o == 1'b1, "R12 idle", idle_o, 1);
        // R9 auto-run re-arms after each upload
        start_run(1, 1);
        cap_body(1, 80, "R9 auto1", -1, 0);
        chk(busy_o == 1'b1, "R9 re-armed", busy_o, 1);
        n = 0;
        cap_body(1, 10, "R9 auto2", -1, 0);
        chk(busy_o == 1'b1, "R9 re-armed again", busy_o, 1);
        n = 0;
        feed(40, -1);
        do_stop();
        readout(40, 0, "R10 stop armed", -1, 0);
        chk(idle_o == 1'b1, "R10 idle after auto stop", idle_o, 1);
        // R10 stop during upload ends auto-run after the upload
        start_run(2, 1);
        cap_body(2, 60, "R10 stop upload", 5, 0);
        chk(idle_o == 1'b1, "R10 idle after upload stop", idle_o, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule